// File: doc/BRIEF.md
# Multi-Layer Bus Crossbar with Per-Slave Default Master

This block is a crossbar interconnect that links four bus masters to five slaves. Each master has its own address decoder, and all decoders use the same fixed address map. Each slave has its own arbiter, so transfers from masters that target different slaves run in the same cycle. No shared bus serializes them.

The transfer handshake is a simplified single-phase form of a pipelined system bus. A master raises `m_valid` with its address, direction and write data. It holds all of them steady until it sees `m_ready` high, and that cycle completes the transfer. The slave side uses the same rule with `s_valid` and `s_ready`. Read data and an error flag return on the cycle in which ready is high.

Each slave arbiter keeps a default master, which is the most recent master it granted. A request from the default master is passed to the slave combinationally, with no added cycle. Any other master is recorded by the arbiter on the clock edge and reaches the slave one cycle later. That master then becomes the new default.

Top module: `xbar_top`

## Requirements
- R1: The address map has five regions. Slave 0 covers 0x2000_0000 to 0x2003_FFFF, slave 1 covers 0x0080_0000 to 0x0083_FFFF, slave 2 covers 0x0040_0000 to 0x0043_FFFF, slave 3 covers 0x6000_0000 to 0x6003_FFFF, and slave 4 covers 0x4000_0000 to 0x5FFF_FFFF. A connected request appears only on the slave whose region holds its address, with address, write flag and write data unchanged. That slave's `s_ready`, `s_err` and `s_rdata` return to the master in the same cycle.
- R2: A valid request whose address is in no region gets `m_ready`=1 and `m_err`=1 in the same cycle, with `m_rdata` zero. No slave sees it.
- R3: Masters connected to different slaves complete transfers in the same cycle.
- R4: A request from a slave's default master drives `s_valid` of that slave in the same cycle as `m_valid`.
- R5: A request from another master to a slave whose default master is idle drives `s_valid` exactly one cycle later. The requester is then the default, so its next request to that slave is seen with zero added latency.
- R6: While a connected transfer waits with `s_ready` low, the slave keeps the same master. Its outputs stay stable, and competing masters see `m_ready` low.
- R7: When the default master is idle, or its transfer completes, and other masters are waiting, the next owner is the first waiting master found after the default in ascending cyclic index order (…, 3, 0, 1, …).
- R8: After reset, master 0 is the default of every slave, all `s_valid` are low, and `m_ready` is low for idle masters.
- R9: A master with a valid, decodable request that is not connected sees `m_ready`=0, `m_err`=0 and `m_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | NM | Per-master request valid |
| m_addr | input | NM×32 | Per-master address |
| m_write | input | NM | Per-master write flag |
| m_wdata | input | NM×DW | Per-master write data |
| m_ready | output | NM | Per-master transfer complete |
| m_err | output | NM | Per-master error response |
| m_rdata | output | NM×DW | Per-master read data |
| s_valid | output | 5 | Per-slave request valid |
| s_addr | output | 5×32 | Per-slave address |
| s_write | output | 5 | Per-slave write flag |
| s_wdata | output | 5×DW | Per-slave write data |
| s_ready | input | 5 | Per-slave transfer complete |
| s_err | input | 5 | Per-slave error response |
| s_rdata | input | 5×DW | Per-slave read data |

## Verification
The hardest case to reach is a slave stalled mid-transfer while another master queues behind it. That scene tests both the stable handoff and the choice of the next owner. The bench builds it directly: it holds one slave's ready low after a master connects, adds a competing request, and releases ready only after several stalled cycles. For the cyclic wrap of the arbitration order, the bench first moves a slave's default to master 3 and then has masters 0 and 2 request together. Random traffic then crowds four masters onto two favoured slaves with random slave stalls, and a behavioural model is compared on every cycle.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int NUM_SLV = 5;
  localparam int ADDR_W  = 32;

  // Base address and log2 of region size per slave port
  localparam logic [ADDR_W-1:0] REGION_BASE [NUM_SLV] = '{
    32'h2000_0000, 32'h0080_0000, 32'h0040_0000, 32'h6000_0000, 32'h4000_0000
  };
  localparam int REGION_LOG2 [NUM_SLV] = '{18, 18, 18, 18, 29};

  function automatic logic region_hit(input int idx, input logic [ADDR_W-1:0] addr);
    logic [ADDR_W-1:0] mask;
    mask = ~((ADDR_W'(1) << REGION_LOG2[idx]) - ADDR_W'(1));
    return (addr & mask) == (REGION_BASE[idx] & mask);
  endfunction

endpackage

// File: rtl/xbar_decoder.sv
module xbar_decoder
  import xbar_pkg::*;
(
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_SLV-1:0] sel,
  output logic              miss
);

  logic [NUM_SLV-1:0] hit;

  always_comb begin
    hit = '0;
    for (int j = 0; j < NUM_SLV; j++) begin
      hit[j] = region_hit(j, addr);
    end
  end

  assign sel  = valid ? hit : '0;
  assign miss = valid & ~(|hit);

endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter #(
  parameter int NM        = 4,
  parameter int RST_OWNER = 0,
  localparam int IW       = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic          s_ready,
  output logic [IW-1:0] owner,
  output logic [NM-1:0] conn,
  output logic          s_valid
);

  logic [IW-1:0] owner_q;
  logic [IW-1:0] owner_d;
  logic [IW-1:0] pick;
  logic [NM-1:0] others;
  logic          own_req;
  logic          any_other;
  logic          switch_en;

  // Next-state: keep the owner during its transfer, else rotate to the
  // first waiting master after the owner in cyclic order.
  always_comb begin
    own_req   = req[owner_q];
    others    = req;
    others[owner_q] = 1'b0;
    any_other = |others;
    pick      = owner_q;
    for (int k = NM - 1; k >= 1; k--) begin
      if (others[(int'(owner_q) + k) % NM]) begin
        pick = IW'((int'(owner_q) + k) % NM);
      end
    end
    switch_en = any_other & (~own_req | s_ready);
    owner_d   = switch_en ? pick : owner_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= IW'(RST_OWNER);
    end else if (switch_en) begin
      owner_q <= owner_d;
    end
  end

  assign owner   = owner_q;
  assign s_valid = own_req;
  assign conn    = own_req ? (NM'(1) << owner_q) : '0;

  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> $stable(owner_q)); // R6

  AST_IDLE_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!req[owner_q] && $countones(req) == 1) |=> (conn == $past(req))); // R5

endmodule

// File: rtl/xbar_top.sv
module xbar_top
  import xbar_pkg::*;
#(
  parameter int NM        = 4,
  parameter int DW        = 32,
  parameter int RST_OWNER = 0,
  localparam int NS       = NUM_SLV,
  localparam int AW       = ADDR_W,
  localparam int IW       = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NM-1:0]          m_valid,
  input  logic [NM-1:0][AW-1:0]  m_addr,
  input  logic [NM-1:0]          m_write,
  input  logic [NM-1:0][DW-1:0]  m_wdata,
  output logic [NM-1:0]          m_ready,
  output logic [NM-1:0]          m_err,
  output logic [NM-1:0][DW-1:0]  m_rdata,
  output logic [NS-1:0]          s_valid,
  output logic [NS-1:0][AW-1:0]  s_addr,
  output logic [NS-1:0]          s_write,
  output logic [NS-1:0][DW-1:0]  s_wdata,
  input  logic [NS-1:0]          s_ready,
  input  logic [NS-1:0]          s_err,
  input  logic [NS-1:0][DW-1:0]  s_rdata
);

  logic [NS-1:0] sel_m  [NM];
  logic [NM-1:0] miss;
  logic [NM-1:0] req_s  [NS];
  logic [NM-1:0] conn_s [NS];
  logic [IW-1:0] owner_s [NS];
  logic [NS-1:0] link_m [NM];

  // One decoder per master, all with the same map
  for (genvar m = 0; m < NM; m++) begin : g_dec
    xbar_decoder u_dec (
      .valid (m_valid[m]),
      .addr  (m_addr[m]),
      .sel   (sel_m[m]),
      .miss  (miss[m])
    );
  end

  always_comb begin
    for (int j = 0; j < NS; j++) begin
      for (int m = 0; m < NM; m++) begin
        req_s[j][m]  = sel_m[m][j];
        link_m[m][j] = conn_s[j][m];
      end
    end
  end

  // One arbiter and forward mux per slave
  for (genvar j = 0; j < NS; j++) begin : g_slv
    xbar_arbiter #(.NM(NM), .RST_OWNER(RST_OWNER)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_s[j]),
      .s_ready (s_ready[j]),
      .owner   (owner_s[j]),
      .conn    (conn_s[j]),
      .s_valid (s_valid[j])
    );

    assign s_addr[j]  = m_addr[owner_s[j]];
    assign s_write[j] = m_write[owner_s[j]];
    assign s_wdata[j] = m_wdata[owner_s[j]];

    AST_ROUTE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid[j] |-> region_hit(j, s_addr[j])); // R1
  end

  // Return path per master
  always_comb begin
    for (int m = 0; m < NM; m++) begin
      m_ready[m] = miss[m];
      m_err[m]   = miss[m];
      m_rdata[m] = '0;
      for (int j = 0; j < NS; j++) begin
        if (conn_s[j][m]) begin
          m_ready[m] = s_ready[j];
          m_err[m]   = s_err[j];
          m_rdata[m] = s_rdata[j];
        end
      end
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_chk
    AST_ONE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(link_m[m])); // R3

    AST_MISS_NOSLAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[m] && miss[m]) |-> (link_m[m] == '0 && m_ready[m])); // R2

    AST_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[m] && !miss[m] && link_m[m] == '0) |-> !m_ready[m]); // R9
  end

endmodule

// File: tb/tb_xbar_top.sv
module tb_xbar_top;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int NS = 5;

  logic clk;
  logic rst_n;
  logic [NM-1:0]         m_valid;
  logic [NM-1:0][31:0]   m_addr;
  logic [NM-1:0]         m_write;
  logic [NM-1:0][31:0]   m_wdata;
  logic [NM-1:0]         m_ready;
  logic [NM-1:0]         m_err;
  logic [NM-1:0][31:0]   m_rdata;
  logic [NS-1:0]         s_valid;
  logic [NS-1:0][31:0]   s_addr;
  logic [NS-1:0]         s_write;
  logic [NS-1:0][31:0]   s_wdata;
  logic [NS-1:0]         s_ready;
  logic [NS-1:0]         s_err;
  logic [NS-1:0][31:0]   s_rdata;

  xbar_top dut (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_addr(m_addr), .m_write(m_write), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata),
    .s_valid(s_valid), .s_addr(s_addr), .s_write(s_write), .s_wdata(s_wdata),
    .s_ready(s_ready), .s_err(s_err), .s_rdata(s_rdata)
  );

  // Bench slaves: data is the address folded with the slave number
  always_comb begin
    for (int j = 0; j < NS; j++) begin
      s_rdata[j] = s_addr[j] ^ (32'hA5A5_0000 + 32'(j));
      s_err[j]   = s_valid[j] && (s_addr[j][3:0] == 4'hC);
    end
  end

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk;
  int n_fail;
  int mo [NS];
  logic [NS-1:0]       obs_sv;
  logic [NM-1:0]       obs_rdy;
  logic [NM-1:0]       obs_err;
  logic [NS-1:0][31:0] obs_sa;
  logic [NM-1:0][31:0] obs_rd;
  int done_q [$];

  function automatic int tgt(input logic [31:0] a);
    if (a >= 32'h2000_0000 && a < 32'h2004_0000) return 0;
    if (a >= 32'h0080_0000 && a < 32'h0084_0000) return 1;
    if (a >= 32'h0040_0000 && a < 32'h0044_0000) return 2;
    if (a >= 32'h6000_0000 && a < 32'h6004_0000) return 3;
    if (a >= 32'h4000_0000 && a < 32'h6000_0000) return 4;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Compare one cycle against the model, then advance to the next negedge
  task automatic step();
    int nmo [NS];
    logic [NM-1:0] ack;
    #1;
    for (int j = 0; j < NS; j++) begin
      int own;
      bit ownreq;
      bit anyo;
      own    = mo[j];
      ownreq = m_valid[own] && (tgt(m_addr[own]) == j);
      chk(s_valid[j] == ownreq, "R5", $sformatf("s_valid[%0d]", j), 32'(s_valid[j]), 32'(ownreq));
      if (ownreq) begin
        chk(s_addr[j] == m_addr[own], "R1", "s_addr", s_addr[j], m_addr[own]);
        chk(s_write[j] == m_write[own], "R1", "s_write", 32'(s_write[j]), 32'(m_write[own]));
        chk(s_wdata[j] == m_wdata[own], "R1", "s_wdata", s_wdata[j], m_wdata[own]);
      end
      nmo[j] = own;
      anyo = 1'b0;
      for (int m = 0; m < NM; m++)
        if (m != own && m_valid[m] && tgt(m_addr[m]) == j) anyo = 1'b1;
      if (anyo && (!ownreq || s_ready[j])) begin
        for (int k = NM - 1; k >= 1; k--) begin
          int c;
          c = (own + k) % NM;
          if (m_valid[c] && tgt(m_addr[c]) == j) nmo[j] = c;
        end
      end
    end
    for (int m = 0; m < NM; m++) begin
      int t;
      logic er, ee;
      logic [31:0] ed;
      t = tgt(m_addr[m]);
      er = 1'b0; ee = 1'b0; ed = '0;
      if (m_valid[m]) begin
        if (t < 0) begin
          er = 1'b1; ee = 1'b1;
        end else if (mo[t] == m) begin
          er = s_ready[t];
          ee = (m_addr[m][3:0] == 4'hC);
          ed = m_addr[m] ^ (32'hA5A5_0000 + 32'(t));
        end
      end
      chk(m_ready[m] == er, "R9", $sformatf("m_ready[%0d]", m), 32'(m_ready[m]), 32'(er));
      chk(m_err[m] == ee, "R2", $sformatf("m_err[%0d]", m), 32'(m_err[m]), 32'(ee));
      chk(m_rdata[m] == ed, "R1", $sformatf("m_rdata[%0d]", m), m_rdata[m], ed);
    end
    obs_sv = s_valid; obs_rdy = m_ready; obs_err = m_err; obs_sa = s_addr; obs_rd = m_rdata;
    ack = m_valid & m_ready;
    for (int m = 0; m < NM; m++) if (ack[m]) done_q.push_back(m);
    @(negedge clk);
    for (int j = 0; j < NS; j++) mo[j] = nmo[j];
    for (int m = 0; m < NM; m++) if (ack[m]) m_valid[m] = 1'b0;
  endtask

  task automatic req(input int m, input logic [31:0] a);
    m_valid[m] = 1'b1;
    m_addr[m]  = a;
    m_write[m] = 1'b0;
    m_wdata[m] = a + 32'h1111;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    m_valid = '0; m_addr = '0; m_write = '0; m_wdata = '0;
    s_ready = '1;
    for (int j = 0; j < NS; j++) mo[j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(s_valid == '0, "R8", "s_valid after reset", 32'(s_valid), 0);
    chk(m_ready == '0, "R8", "m_ready after reset", 32'(m_ready), 0);
    @(negedge clk);

    // R4: master 0 is default of slave 2 after reset
    req(0, 32'h0040_0010);
    step();
    chk(obs_sv[2] == 1'b1, "R4", "zero-latency s_valid", 32'(obs_sv[2]), 1);
    chk(obs_rd[0] == (32'h0040_0010 ^ 32'hA5A5_0002), "R1", "read data", obs_rd[0], 32'h0040_0010 ^ 32'hA5A5_0002);

    // R5: master 1 to idle slave 3 pays one cycle, then is default
    req(1, 32'h6000_0020);
    step();
    chk(obs_sv[3] == 1'b0 && obs_rdy[1] == 1'b0, "R5", "penalty cycle", 32'(obs_sv[3]), 0);
    step();
    chk(obs_sv[3] == 1'b1 && obs_rdy[1] == 1'b1, "R5", "connected after one cycle", 32'(obs_sv[3]), 1);
    req(1, 32'h6000_0024);
    step();
    chk(obs_sv[3] == 1'b1, "R5", "new default zero latency", 32'(obs_sv[3]), 1);

    // R6: stalled transfer on slave 0 keeps its owner
    s_ready[0] = 1'b0;
    req(2, 32'h2000_0100);
    step();
    step();
    chk(obs_sv[0] == 1'b1, "R6", "stalled transfer connected", 32'(obs_sv[0]), 1);
    req(3, 32'h2000_0200);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(obs_sa[0] == 32'h2000_0100, "R6", "slave address held", obs_sa[0], 32'h2000_0100);
      chk(obs_rdy[3] == 1'b0, "R6", "competitor waits", 32'(obs_rdy[3]), 0);
    end
    s_ready[0] = 1'b1;
    step();
    chk(obs_rdy[2] == 1'b1, "R6", "stalled transfer completes", 32'(obs_rdy[2]), 1);
    step();
    chk(obs_sv[0] && obs_sa[0] == 32'h2000_0200 && obs_rdy[3], "R7", "handoff to waiting master", obs_sa[0], 32'h2000_0200);

    // R7: cyclic order on slave 1 (default 0)
    done_q.delete();
    req(1, 32'h0080_0004); req(2, 32'h0080_0008); req(3, 32'h0080_0010);
    for (int i = 0; i < 10 && done_q.size() < 3; i++) step();
    chk(done_q.size() == 3, "R7", "all granted", done_q.size(), 3);
    for (int i = 0; i < 3 && i < done_q.size(); i++)
      chk(done_q[i] == i + 1, "R7", "grant order", done_q[i], i + 1);
    done_q.delete();
    req(0, 32'h0080_0020); req(2, 32'h0080_0024);
    for (int i = 0; i < 10 && done_q.size() < 2; i++) step();
    chk(done_q.size() == 2 && done_q[0] == 0 && done_q[1] == 2, "R7", "wrap order", done_q.size() > 0 ? done_q[0] : -1, 0);

    // R3: two slaves served in the same cycle (slave 2 default 0, slave 0 default 3)
    req(0, 32'h0040_0040); req(3, 32'h2000_0040);
    step();
    chk(obs_rdy[0] && obs_rdy[3] && obs_sv[2] && obs_sv[0], "R3", "concurrent transfers", 32'(obs_rdy), 32'h9);

    // R2: unmapped addresses, including one just past slave 3
    req(1, 32'h1000_0000);
    step();
    chk(obs_rdy[1] && obs_err[1] && obs_sv == '0, "R2", "unmapped access", 32'(obs_err[1]), 1);
    req(1, 32'h6004_0000);
    step();
    chk(obs_rdy[1] && obs_err[1], "R2", "just past region", 32'(obs_err[1]), 1);

    // R1: top of the large region reaches slave 4
    req(2, 32'h5FFF_FFF0);
    step();
    step();
    chk(obs_sv[4] && obs_sa[4] == 32'h5FFF_FFF0, "R1", "top of slave 4 region", obs_sa[4], 32'h5FFF_FFF0);

    // Random concurrent traffic
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int m = 0; m < NM; m++) begin
        if (!m_valid[m] && ($urandom % 3 == 0)) begin
          int r, sl;
          logic [31:0] a;
          r = $urandom % 16;
          if (r < 2) a = 32'h1000_0000 + ($urandom & 32'hFFC);
          else begin
            sl = ($urandom % 4 == 0) ? int'($urandom % 5) : int'($urandom % 2);
            case (sl)
              0: a = 32'h2000_0000 + ($urandom & 32'h3FFFC);
              1: a = 32'h0080_0000 + ($urandom & 32'h3FFFC);
              2: a = 32'h0040_0000 + ($urandom & 32'h3FFFC);
              3: a = 32'h6000_0000 + ($urandom & 32'h3FFFC);
              default: a = 32'h4000_0000 + ($urandom & 32'h1FFF_FFFC);
            endcase
          end
          m_valid[m] = 1'b1;
          m_addr[m]  = a;
          m_write[m] = 1'($urandom);
          m_wdata[m] = $urandom;
        end
      end
      for (int j = 0; j < NS; j++) s_ready[j] = ($urandom % 10) < 7;
      step();
    end

    finish_run();
  end

endmodule